// File: doc/BRIEF.md
# Multi-Channel DAC Control Register Bank

This block is the digital front end for a set of 12-bit voltage-output converters. Software sees one control word and one data word per channel on a single-cycle 32-bit read/write bus. For each channel the block drives a 12-bit conversion code, a 2-bit reference-range select and an output enable. The analog converter, its buffer, the reference switching and the timer are outside this block.

Each channel keeps a holding register, which is the software-visible data word, in front of a separate output latch that feeds the converter. A per-channel control bit chooses when the latch loads. In immediate mode it copies the holding register on every core clock. In timer mode it loads only on a clock edge where the shared `timer_tick` pulse input is high. This lets several channels be written ahead of time and then change together.

A second control bit is an active-low clear that holds the channel's data word at zero. A range code of 00 powers the channel down. Powering down drops the output enable but leaves the latched code in place, so the old value returns when the range is set again.

Top module: `dac_regbank`

## Requirements
- R1: After reset every control and data word reads 0, and every channel drives code 0, range 00 and output enable low.
- R2: Channel n's control word is at address 0x600 + 8·n and its data word at 0x604 + 8·n (n = 0..3). Read data appears on `rdata` in the cycle after `rd_en`. `rdata` is 0 in any cycle that does not follow a read.
- R3: Control word layout: bit 5 selects the update source (1 = timer, 0 = immediate), bit 4 is the run bit (0 = clear), and bits 1:0 are the range. All other bits read 0 and ignore writes, so writing 0xFFFFFFFF reads back 0x33.
- R4: The 12-bit code sits in data word bits 27:16. Bits 31:28 and 15:0 read 0 and ignore writes.
- R5: A write to an address outside the map changes no register. A read from such an address returns 0.
- R6: In immediate mode, a channel's output code equals its holding register one clock later. A data write sampled at edge k shows on `dac_code` after edge k+1.
- R7: In timer mode, the output code changes only at an edge where `timer_tick` is high, and then takes the holding register value. Data writes alone leave the code unchanged.
- R8: While the run bit is 0, the channel's data word is forced to 0 from the next edge on, and data writes to it are ignored.
- R9: `dac_range` for a channel equals its control bits 1:0, and its `dac_oe` is low exactly when that range is 00.
- R10: Powering a channel down (range 00) and up again leaves its output code unchanged.
- R11: Channels are independent: a write to one channel, or a timer pulse, does not alter a channel that is not addressed or is in immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | 32 | Bus byte address |
| wdata | input | 32 | Bus write data |
| rdata | output | 32 | Bus read data, valid the cycle after `rd_en` |
| timer_tick | input | 1 | Update pulse for channels in timer mode |
| dac_code | output | 48 | Channel n code in bits 12n+11:12n |
| dac_range | output | 8 | Channel n range in bits 2n+1:2n |
| dac_oe | output | 4 | Channel n output enable in bit n |

## Verification
The checker assumes that `wr_en` and `rd_en` are never high in the same cycle, and that every input is a known value once the internal reset has released. It also assumes `timer_tick` is sampled only as a level at the clock edge, so a pulse of any length counts once per edge. The bench drives all inputs on the falling clock edge and issues one bus operation per task call, never both strobes together. It raises `timer_tick` for exactly one cycle, so each pulse produces a single latch load that can be checked on a known edge.

// File: rtl/dac_regbank_pkg.sv
package dac_regbank_pkg;

  // Control-word bit positions that software relies on.
  localparam int CTL_SRC_BIT = 5;
  localparam int CTL_RUN_BIT = 4;
  localparam int CTL_RNG_LSB = 0;
  localparam int CTL_USED_W  = 6;

  typedef enum logic [1:0] {
    RNG_OFF    = 2'b00,
    RNG_EXTREF = 2'b01,
    RNG_BGAP   = 2'b10,
    RNG_SUPPLY = 2'b11
  } dac_rng_e;

  typedef struct packed {
    logic     upd_timer;
    logic     run;
    dac_rng_e rng;
  } dac_ctl_t;

endpackage

// File: rtl/dac_rst_sync.sv
module dac_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];

endmodule

// File: rtl/dac_addr_decode.sv
module dac_addr_decode #(
  parameter int NUM_CH    = 4,
  parameter int ADDR_W    = 32,
  parameter int BASE_ADDR = 'h600,
  parameter int CH_STRIDE = 8,
  parameter int DAT_OFF   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] ctl_hit,
  output logic [NUM_CH-1:0] dat_hit,
  output logic              any_hit
);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    localparam logic [ADDR_W-1:0] CTL_A = ADDR_W'(BASE_ADDR + CH_STRIDE * i);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_ADDR + CH_STRIDE * i + DAT_OFF);
    assign ctl_hit[i] = (addr == CTL_A);
    assign dat_hit[i] = (addr == DAT_A);
  end

  assign any_hit = |{ctl_hit, dat_hit};

endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_regbank_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              ctl_we,
  input  logic              dat_we,
  input  dac_ctl_t          ctl_wr,
  input  logic [CODE_W-1:0] code_wr,
  input  logic              timer_tick,
  output dac_ctl_t          ctl_q,
  output logic [CODE_W-1:0] hold_q,
  output logic [CODE_W-1:0] code_q
);

  dac_ctl_t          ctl_d;
  logic [CODE_W-1:0] hold_d;
  logic [CODE_W-1:0] code_d;
  logic              latch_en;

  always_comb begin
    ctl_d = ctl_we ? ctl_wr : ctl_q;

    // clear has priority over a data write
    if (!ctl_q.run) begin
      hold_d = '0;
    end else if (dat_we) begin
      hold_d = code_wr;
    end else begin
      hold_d = hold_q;
    end

    latch_en = ctl_q.upd_timer ? timer_tick : 1'b1;
    code_d   = latch_en ? hold_q : code_q;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ctl_q  <= '0;
      hold_q <= '0;
      code_q <= '0;
    end else begin
      ctl_q  <= ctl_d;
      hold_q <= hold_d;
      code_q <= code_d;
    end
  end

endmodule

// File: rtl/dac_rd_mux.sv
module dac_rd_mux
  import dac_regbank_pkg::*;
#(
  parameter int NUM_CH   = 4,
  parameter int CODE_W   = 12,
  parameter int DATA_W   = 32,
  parameter int CODE_LSB = 16
) (
  input  logic              clk,
  input  logic              srst_n,
  input  logic              rd_en,
  input  logic [NUM_CH-1:0] ctl_hit,
  input  logic [NUM_CH-1:0] dat_hit,
  input  dac_ctl_t          ctl   [NUM_CH],
  input  logic [CODE_W-1:0] hold  [NUM_CH],
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] rdata_d;

  always_comb begin
    word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ctl_hit[i]) begin
        word = word | DATA_W'({ctl[i].upd_timer, ctl[i].run, 2'b00, ctl[i].rng});
      end
      if (dat_hit[i]) begin
        word = word | (DATA_W'(hold[i]) << CODE_LSB);
      end
    end
    rdata_d = rd_en ? word : '0;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rdata <= '0;
    end else begin
      rdata <= rdata_d;
    end
  end

endmodule

// File: rtl/dac_regbank.sv
module dac_regbank
  import dac_regbank_pkg::*;
#(
  parameter int NUM_CH    = 4,
  parameter int CODE_W    = 12,
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int CODE_LSB  = 16,
  parameter int BASE_ADDR = 'h600,
  parameter int CH_STRIDE = 8,
  parameter int SYNC_STG  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic                       rd_en,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  output logic [DATA_W-1:0]          rdata,
  input  logic                       timer_tick,
  output logic [NUM_CH*CODE_W-1:0]   dac_code,
  output logic [NUM_CH*2-1:0]        dac_range,
  output logic [NUM_CH-1:0]          dac_oe
);

  localparam int DAT_OFF = CH_STRIDE / 2;

  logic              srst_n;
  logic [NUM_CH-1:0] ctl_hit;
  logic [NUM_CH-1:0] dat_hit;
  logic              any_hit;
  dac_ctl_t          ctl_wr;
  logic [CODE_W-1:0] code_wr;
  dac_ctl_t          ctl_q  [NUM_CH];
  logic [CODE_W-1:0] hold_q [NUM_CH];
  logic [CODE_W-1:0] code_q [NUM_CH];

  // flattened views used by the bound checker
  logic [NUM_CH-1:0]        ch_upd;
  logic [NUM_CH-1:0]        ch_run;
  logic [NUM_CH*CODE_W-1:0] ch_hold;
  logic                     unused_wbits;

  dac_rst_sync #(.STAGES(SYNC_STG)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  dac_addr_decode #(
    .NUM_CH    (NUM_CH),
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .CH_STRIDE (CH_STRIDE),
    .DAT_OFF   (DAT_OFF)
  ) u_dec (
    .addr    (addr),
    .ctl_hit (ctl_hit),
    .dat_hit (dat_hit),
    .any_hit (any_hit)
  );

  always_comb begin
    ctl_wr.upd_timer = wdata[CTL_SRC_BIT];
    ctl_wr.run       = wdata[CTL_RUN_BIT];
    ctl_wr.rng       = dac_rng_e'(wdata[CTL_RNG_LSB +: 2]);
    code_wr          = wdata[CODE_LSB +: CODE_W];
  end

  assign unused_wbits = ^wdata;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dac_chan #(.CODE_W(CODE_W)) u_chan (
      .clk        (clk),
      .srst_n     (srst_n),
      .ctl_we     (wr_en & ctl_hit[i]),
      .dat_we     (wr_en & dat_hit[i]),
      .ctl_wr     (ctl_wr),
      .code_wr    (code_wr),
      .timer_tick (timer_tick),
      .ctl_q      (ctl_q[i]),
      .hold_q     (hold_q[i]),
      .code_q     (code_q[i])
    );

    assign dac_code[i*CODE_W +: CODE_W] = code_q[i];
    assign dac_range[i*2 +: 2]          = ctl_q[i].rng;
    assign dac_oe[i]                    = (ctl_q[i].rng != RNG_OFF);
    assign ch_upd[i]                    = ctl_q[i].upd_timer;
    assign ch_run[i]                    = ctl_q[i].run;
    assign ch_hold[i*CODE_W +: CODE_W]  = hold_q[i];
  end

  dac_rd_mux #(
    .NUM_CH   (NUM_CH),
    .CODE_W   (CODE_W),
    .DATA_W   (DATA_W),
    .CODE_LSB (CODE_LSB)
  ) u_rd (
    .clk     (clk),
    .srst_n  (srst_n),
    .rd_en   (rd_en),
    .ctl_hit (ctl_hit),
    .dat_hit (dat_hit),
    .ctl     (ctl_q),
    .hold    (hold_q),
    .rdata   (rdata)
  );

endmodule

// File: rtl/dac_regbank_chk.sv
module dac_regbank_chk #(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int DATA_W = 32
) (
  input logic                     clk,
  input logic                     srst_n,
  input logic                     rd_en,
  input logic                     any_hit,
  input logic                     timer_tick,
  input logic [DATA_W-1:0]        rdata,
  input logic [NUM_CH-1:0]        ch_upd,
  input logic [NUM_CH-1:0]        ch_run,
  input logic [NUM_CH*CODE_W-1:0] ch_hold,
  input logic [NUM_CH*CODE_W-1:0] dac_code
);

  // R2
  idle_rdata_chk: assert property (@(posedge clk) disable iff (!srst_n)
    !rd_en |=> rdata == '0);

  // R5
  miss_rdata_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (rd_en && !any_hit) |=> rdata == '0);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch_chk
    // R7
    timer_hold_chk: assert property (@(posedge clk) disable iff (!srst_n)
      (ch_upd[i] && !timer_tick) |=> $stable(dac_code[i*CODE_W +: CODE_W]));

    // R6
    follow_chk: assert property (@(posedge clk) disable iff (!srst_n)
      !ch_upd[i] |=> dac_code[i*CODE_W +: CODE_W] == $past(ch_hold[i*CODE_W +: CODE_W]));

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (!srst_n)
      !ch_run[i] |=> ch_hold[i*CODE_W +: CODE_W] == '0);
  end

endmodule

bind dac_regbank dac_regbank_chk #(
  .NUM_CH (NUM_CH),
  .CODE_W (CODE_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk        (clk),
  .srst_n     (srst_n),
  .rd_en      (rd_en),
  .any_hit    (any_hit),
  .timer_tick (timer_tick),
  .rdata      (rdata),
  .ch_upd     (ch_upd),
  .ch_run     (ch_run),
  .ch_hold    (ch_hold),
  .dac_code   (dac_code)
);

// File: tb/dac_regbank_bench.sv
module dac_regbank_bench;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic        rd_en;
  logic [31:0] addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        timer_tick;
  logic [47:0] dac_code;
  logic [7:0]  dac_range;
  logic [3:0]  dac_oe;

  int n_chk  = 0;
  int n_fail = 0;

  dac_regbank u_dac_regbank (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .rdata      (rdata),
    .timer_tick (timer_tick),
    .dac_code   (dac_code),
    .dac_range  (dac_range),
    .dac_oe     (dac_oe)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {req, is_read, addr, data_or_expected}
  localparam int NV = 20;
  localparam logic [72:0] VEC [NV] = '{
    {8'd1, 1'b1, 32'h600, 32'h0000_0000},  // R1
    {8'd1, 1'b1, 32'h604, 32'h0000_0000},
    {8'd1, 1'b1, 32'h61C, 32'h0000_0000},
    {8'd3, 1'b0, 32'h600, 32'hFFFF_FFFF},  // R3
    {8'd3, 1'b1, 32'h600, 32'h0000_0033},
    {8'd4, 1'b0, 32'h604, 32'hFFFF_FFFF},  // R4
    {8'd4, 1'b1, 32'h604, 32'h0FFF_0000},
    {8'd2, 1'b0, 32'h608, 32'h0000_0012},  // R2
    {8'd2, 1'b1, 32'h608, 32'h0000_0012},
    {8'd4, 1'b0, 32'h60C, 32'h0ABC_1234},
    {8'd4, 1'b1, 32'h60C, 32'h0ABC_0000},
    {8'd5, 1'b0, 32'h620, 32'hFFFF_FFFF},  // R5
    {8'd5, 1'b1, 32'h620, 32'h0000_0000},
    {8'd5, 1'b0, 32'h602, 32'hFFFF_FFFF},
    {8'd5, 1'b1, 32'h602, 32'h0000_0000},
    {8'd5, 1'b0, 32'h5FC, 32'hFFFF_FFFF},
    {8'd2, 1'b0, 32'h618, 32'h0000_0010},
    {8'd2, 1'b1, 32'h618, 32'h0000_0010},
    {8'd5, 1'b1, 32'h600, 32'h0000_0033},
    {8'd5, 1'b1, 32'h604, 32'h0FFF_0000}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0; addr = '0;
    d = rdata;
  endtask

  task automatic tick();
    @(negedge clk);
    timer_tick = 1'b1;
    @(negedge clk);
    timer_tick = 1'b0;
  endtask

  function automatic logic [31:0] code_of(input int ch);
    return 32'(dac_code[ch*12 +: 12]);
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; timer_tick = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 outputs after reset
    check("R1 code", {16'h0, dac_code[47:32]}, 32'h0);
    check("R1 code lo", dac_code[31:0], 32'h0);
    check("R1 range", {24'h0, dac_range}, 32'h0);
    check("R1 oe", {28'h0, dac_oe}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][64]) begin
        bus_read(VEC[v][63:32], rd);
        check($sformatf("R%0d vec%0d", VEC[v][72:65], v), rd, VEC[v][31:0]);
      end else begin
        bus_write(VEC[v][63:32], VEC[v][31:0]);
      end
    end

    // R7 ch0 in timer mode, holding 0xFFF but no tick yet
    check("R7 no tick", code_of(0), 32'h0);
    // R6 ch1 immediate mode, range 10
    check("R6 ch1 code", code_of(1), 32'hABC);
    check("R9 ch1 range", {30'h0, dac_range[3:2]}, 32'h2);
    check("R9 ch1 oe", {31'h0, dac_oe[1]}, 32'h1);
    check("R9 ch3 oe off", {31'h0, dac_oe[3]}, 32'h0);

    // R6 exact latency: one edge after the write edge the code is still old
    bus_write(32'h60C, 32'h0123_0000);
    check("R6 lag", code_of(1), 32'hABC);
    @(negedge clk);
    check("R6 follow", code_of(1), 32'h123);

    // R7 tick loads ch0, R11 ch1 unaffected
    tick();
    check("R7 tick load", code_of(0), 32'hFFF);
    check("R11 ch1 kept", code_of(1), 32'h123);
    bus_write(32'h604, 32'h0456_0000);
    repeat (3) @(negedge clk);
    check("R7 write no load", code_of(0), 32'hFFF);
    tick();
    check("R7 second tick", code_of(0), 32'h456);

    // R8 clear on ch0 (timer mode, range 11)
    bus_write(32'h600, 32'h0000_0023);
    bus_read(32'h604, rd);
    check("R8 cleared", rd, 32'h0);
    bus_write(32'h604, 32'h0777_0000);
    bus_read(32'h604, rd);
    check("R8 write ignored", rd, 32'h0);
    check("R7 clear keeps latch", code_of(0), 32'h456);
    tick();
    check("R8 tick loads zero", code_of(0), 32'h0);
    // R8 clear on ch1 in immediate mode
    bus_write(32'h608, 32'h0000_0002);
    repeat (2) @(negedge clk);
    check("R8 ch1 zero", code_of(1), 32'h0);

    // R9 R10 ch2 range and power-down
    bus_write(32'h610, 32'h0000_0013);
    bus_write(32'h614, 32'h0222_0000);
    @(negedge clk);
    check("R9 ch2 code", code_of(2), 32'h222);
    check("R9 ch2 range", {30'h0, dac_range[5:4]}, 32'h3);
    check("R9 ch2 oe", {31'h0, dac_oe[2]}, 32'h1);
    bus_write(32'h610, 32'h0000_0010);
    check("R9 pd oe", {31'h0, dac_oe[2]}, 32'h0);
    check("R9 pd range", {30'h0, dac_range[5:4]}, 32'h0);
    check("R10 pd code kept", code_of(2), 32'h222);
    bus_write(32'h610, 32'h0000_0011);
    check("R10 up oe", {31'h0, dac_oe[2]}, 32'h1);
    check("R10 up code", code_of(2), 32'h222);
    check("R11 ch0 untouched", code_of(0), 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule